// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the four interrupt status flags of one timer channel and turns them into interrupt requests. Each cycle it compares the running count against two 8-bit compare values, or against one 16-bit value built from both. It also watches an overflow strobe, a synchronized capture-pin event and a TOP-reached strobe. A two-bit mode input decides which of these sources may set a flag. In the 16-bit modes the second compare value serves as a high byte. In the capture modes one compare value serves as a capture register.

Software clears a flag by writing a one to its bit. The interrupt dispatcher clears a flag with a one-cycle acknowledge strobe when it takes the flag's vector. A request line is raised for each source whose flag, enable bit and the global enable are all high. The flags are presented as an 8-bit register view. The bit positions belonging to a neighbouring timer read as zero.

Top module: `tmr_flag_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the flag view and all request lines are 0.
- R2: In mode 0 (8-bit) and mode 3 (capture-as-TOP), the compare-A flag (view bit 4) becomes 1 one clock after `cnt_val[7:0]` equals `cmp_a`.
- R3: In mode 1 (16-bit compare), the compare-A flag becomes 1 one clock after `cnt_val` equals `{cmp_b, cmp_a}`.
- R4: The compare-B flag (view bit 3) becomes 1 one clock after `cnt_val[7:0]` equals `cmp_b` in modes 0 and 3. It never sets in mode 1 or mode 2.
- R5: In mode 2 (16-bit input capture), the compare-A flag never sets.
- R6: The capture flag (view bit 0) sets one clock after `cap_evt` in modes 0, 1 and 2. In mode 3 it sets one clock after `top_stb`, and `cap_evt` is ignored. `top_stb` is ignored in the other modes.
- R7: The overflow flag (view bit 1) sets one clock after `ovf_stb` in every mode.
- R8: A compare match that lasts several cycles sets its flag only at its first cycle. If the flag is cleared while the match persists, it stays clear.
- R9: A flag clears when a write carries a one in its view bit, or when its acknowledge strobe pulses (`ack` index 0 capture, 1 overflow, 2 compare B, 3 compare A). Writing a zero leaves a flag unchanged, and a write never sets a flag.
- R10: If a set event and a clear reach the same flag in the same cycle, the flag ends up set.
- R11: `irq[i]` is 1 exactly when `gie`, `src_en[i]` and flag i are all 1. The index order is the same as for `ack`.
- R12: View bits 7, 6, 5 and 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Current counter value |
| cmp_a | input | 8 | Compare value A (low byte in 16-bit mode) |
| cmp_b | input | 8 | Compare value B (high byte in 16-bit mode) |
| mode | input | 2 | 0 8-bit, 1 16-bit compare, 2 16-bit capture, 3 capture-as-TOP |
| ovf_stb | input | 1 | Counter overflow strobe |
| cap_evt | input | 1 | Synchronized capture-pin event |
| top_stb | input | 1 | Counter reached TOP strobe |
| wr_en | input | 1 | Flag register write strobe |
| wr_data | input | 8 | Write data; a one clears that flag |
| gie | input | 1 | Global interrupt enable |
| src_en | input | 4 | Per-source interrupt enables |
| ack | input | 4 | Per-source vector-taken strobes |
| flags | output | 8 | Flag register view |
| irq | output | 4 | Per-source interrupt requests |

## Verification
Directed sequences pin down single behaviours:
- A held match followed by a clear separates onset detection from level detection.
- A 16-bit count whose low byte alone matches separates the 16-bit compare from the 8-bit one.
- The same pattern replayed in mode 2 shows the suppression of both compare flags.
- A pin event and a TOP strobe in mode 3 and in mode 0 tell apart the two sources of the capture flag.

Random stimulus draws counts and compare values from a narrow range so that matches, mode switches, same-cycle set and clear, and gated requests happen often. A bench model of the flags follows this stimulus cycle by cycle.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;

  typedef enum logic [1:0] {
    TM_8BIT   = 2'd0,
    TM_16CMP  = 2'd1,
    TM_16CAP  = 2'd2,
    TM_CAPTOP = 2'd3
  } tmr_mode_e;

  localparam int NSRC     = 4;
  localparam int SRC_CAP  = 0;
  localparam int SRC_OVF  = 1;
  localparam int SRC_CMPB = 2;
  localparam int SRC_CMPA = 3;

  localparam int VIEW_W = 8;

  // Position of each source flag inside the register view.
  function automatic int src_bit(input int src);
    case (src)
      SRC_CAP:  return 0;
      SRC_OVF:  return 1;
      SRC_CMPB: return 3;
      default:  return 4;
    endcase
  endfunction

endpackage

// File: rtl/tmr_match_edge.sv
// Registered compare: reports the first cycle of a (gated) equality.
module tmr_match_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         onset
);

  logic hit;
  logic hit_q;
  logic hit_d;

  always_comb begin
    hit   = arm && (lhs == rhs);
    hit_d = hit;
    onset = hit && !hit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

endmodule

// File: rtl/tmr_flag_bit.sv
// One sticky flag; a set request wins over a clear in the same cycle.
module tmr_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic q
);

  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_req || clr_req;
    q_d  = set_req ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end

endmodule

// File: rtl/tmr_flag_ctrl.sv
module tmr_flag_ctrl
  import tmr_flag_pkg::*;
#(
  parameter int CW = 8,
  localparam int NW = 2 * CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NW-1:0]     cnt_val,
  input  logic [CW-1:0]     cmp_a,
  input  logic [CW-1:0]     cmp_b,
  input  logic [1:0]        mode,
  input  logic              ovf_stb,
  input  logic              cap_evt,
  input  logic              top_stb,
  input  logic              wr_en,
  input  logic [VIEW_W-1:0] wr_data,
  input  logic              gie,
  input  logic [NSRC-1:0]   src_en,
  input  logic [NSRC-1:0]   ack,
  output logic [VIEW_W-1:0] flags,
  output logic [NSRC-1:0]   irq
);

  tmr_mode_e mode_e;
  logic      wide_cmp;
  logic      arm_a;
  logic      arm_b;
  logic [NW-1:0] a_lhs;
  logic [NW-1:0] a_rhs;
  logic      onset_a;
  logic      onset_b;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] flag_q;

  // Mode decode: which compare sources may fire and at what width.
  always_comb begin
    mode_e   = tmr_mode_e'(mode);
    wide_cmp = (mode_e == TM_16CMP);
    arm_a    = (mode_e != TM_16CAP);
    arm_b    = (mode_e == TM_8BIT) || (mode_e == TM_CAPTOP);
    if (wide_cmp) begin
      a_lhs = cnt_val;
      a_rhs = {cmp_b, cmp_a};
    end else begin
      a_lhs = {{CW{1'b0}}, cnt_val[CW-1:0]};
      a_rhs = {{CW{1'b0}}, cmp_a};
    end
  end

  tmr_match_edge #(.W(NW)) u_match_a (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (arm_a),
    .lhs   (a_lhs),
    .rhs   (a_rhs),
    .onset (onset_a)
  );

  tmr_match_edge #(.W(CW)) u_match_b (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (arm_b),
    .lhs   (cnt_val[CW-1:0]),
    .rhs   (cmp_b),
    .onset (onset_b)
  );

  // Set sources per flag.
  always_comb begin
    set_vec           = '0;
    set_vec[SRC_CMPA] = onset_a;
    set_vec[SRC_CMPB] = onset_b;
    set_vec[SRC_OVF]  = ovf_stb;
    set_vec[SRC_CAP]  = (mode_e == TM_CAPTOP) ? top_stb : cap_evt;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      localparam int VB = src_bit(gi);

      always_comb clr_vec[gi] = ack[gi] || (wr_en && wr_data[VB]);

      tmr_flag_bit u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_vec[gi]),
        .clr_req (clr_vec[gi]),
        .q       (flag_q[gi])
      );

      always_comb irq[gi] = gie && src_en[gi] && flag_q[gi];
    end
  endgenerate

  // Register view; unused positions belong to another timer.
  always_comb begin
    flags = '0;
    for (int i = 0; i < NSRC; i++) flags[src_bit(i)] = flag_q[i];
  end

endmodule

// File: rtl/tmr_flag_ctrl_chk.sv
module tmr_flag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       ovf_stb,
  input logic       cap_evt,
  input logic       top_stb,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [3:0] ack,
  input logic [7:0] flags,
  input logic [3:0] irq
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_clear_R1: assert (flags == 8'h00 && irq == 4'h0);
  end

  assert_unused_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[7:5] == 3'b000) && (flags[2] == 1'b0));

  assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~{flags[4], flags[3], flags[1], flags[0]}) == 4'h0);

  assert_cmpa_clear_cause_R9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $fell(flags[4]) |-> $past(ack[3] || (wr_en && wr_data[4])));

  assert_cmpb_mode_R4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $rose(flags[3]) |-> ($past(mode) == 2'd0 || $past(mode) == 2'd3));

  assert_cmpa_no_capture_R5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $rose(flags[4]) |-> ($past(mode) != 2'd2));

  assert_cap_source_R6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $rose(flags[0]) |-> $past((mode == 2'd3) ? top_stb : cap_evt));

  assert_ovf_sets_R7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(ovf_stb) |-> flags[1]);

endmodule

bind tmr_flag_ctrl tmr_flag_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode    (mode),
  .ovf_stb (ovf_stb),
  .cap_evt (cap_evt),
  .top_stb (top_stb),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .ack     (ack),
  .flags   (flags),
  .irq     (irq)
);

// File: tb/tmr_flag_ctrl_tb.sv
module tmr_flag_ctrl_tb;

  logic        clk;
  logic        rst_n;
  logic [15:0] cnt_val;
  logic [7:0]  cmp_a;
  logic [7:0]  cmp_b;
  logic [1:0]  mode;
  logic        ovf_stb;
  logic        cap_evt;
  logic        top_stb;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic        gie;
  logic [3:0]  src_en;
  logic [3:0]  ack;
  logic [7:0]  flags;
  logic [3:0]  irq;

  int n_cmp;
  int n_bad;
  bit done;

  // Bench model state: [0] cap, [1] ovf, [2] cmp B, [3] cmp A
  logic [3:0] m_flag;
  logic       m_hit_a;
  logic       m_hit_b;

  tmr_flag_ctrl u_dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] view_of(input logic [3:0] f);
    return {3'b000, f[3], f[2], 1'b0, f[1], f[0]};
  endfunction

  function automatic logic hit_a_of(input logic [1:0] md, input logic [15:0] c,
                                    input logic [7:0] a, input logic [7:0] b);
    if (md == 2'd2) return 1'b0;
    if (md == 2'd1) return c == {b, a};
    return c[7:0] == a;
  endfunction

  function automatic logic hit_b_of(input logic [1:0] md, input logic [15:0] c,
                                    input logic [7:0] b);
    return (md == 2'd0 || md == 2'd3) && (c[7:0] == b);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ovf_stb = 0; cap_evt = 0; top_stb = 0; wr_en = 0; wr_data = 0; ack = 0;
  endtask

  // One clock: advance model from the current inputs, then compare at negedge.
  task automatic step(input string req);
    logic [3:0] setv, clrv;
    logic ha, hb;
    ha = hit_a_of(mode, cnt_val, cmp_a, cmp_b);
    hb = hit_b_of(mode, cnt_val, cmp_b);
    setv[3] = ha && !m_hit_a;
    setv[2] = hb && !m_hit_b;
    setv[1] = ovf_stb;
    setv[0] = (mode == 2'd3) ? top_stb : cap_evt;
    clrv[0] = ack[0] || (wr_en && wr_data[0]);
    clrv[1] = ack[1] || (wr_en && wr_data[1]);
    clrv[2] = ack[2] || (wr_en && wr_data[3]);
    clrv[3] = ack[3] || (wr_en && wr_data[4]);
    @(posedge clk);
    m_hit_a = ha;
    m_hit_b = hb;
    m_flag  = setv | (m_flag & ~clrv);
    @(negedge clk);
    check(req, {24'd0, flags}, {24'd0, view_of(m_flag)});
    check({req, " irq R11"}, {28'd0, irq}, {28'd0, {4{gie}} & src_en & m_flag});
    idle_inputs();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    void'($urandom(32'd20240611));
    rst_n = 0; cnt_val = 0; cmp_a = 8'h05; cmp_b = 8'h07; mode = 2'd0;
    gie = 1; src_en = 4'hF;
    idle_inputs();
    m_flag = 0; m_hit_a = 0; m_hit_b = 0;
    repeat (3) @(negedge clk);
    check("R1 reset view", {24'd0, flags}, 32'd0);
    check("R1 reset irq", {28'd0, irq}, 32'd0);
    rst_n = 1;
    step("R1 first cycle");

    // R2 / R8: held match sets once, stays clear after write-one
    cnt_val = 16'h0005;
    step("R2 cmpA set");
    step("R8 held match");
    wr_en = 1; wr_data = 8'h10;
    step("R9 write-one clear");
    step("R8 no re-set while held");
    cnt_val = 16'h0007;
    step("R4 cmpB set mode0");
    wr_en = 1; wr_data = 8'h00;
    step("R9 write zero keeps");
    ack = 4'b0100;
    step("R9 ack clears B");
    cnt_val = 16'h0000;
    wr_en = 1; wr_data = 8'hFF;
    step("R9 write never sets");

    // R7 / R10
    ovf_stb = 1;
    step("R7 overflow");
    ovf_stb = 1; wr_en = 1; wr_data = 8'h02;
    step("R10 set beats clear");
    ack = 4'b0010;
    step("R9 ack clears ovf");

    // R3 16-bit compare; low-byte-only match must not fire
    mode = 2'd1; cmp_a = 8'h05; cmp_b = 8'h12;
    cnt_val = 16'h0005;
    step("R3 low byte only");
    cnt_val = 16'h1205;
    step("R3 16-bit match");
    cnt_val = 16'h0012;
    step("R4 B blocked mode1");
    wr_en = 1; wr_data = 8'hFF;
    step("R9 clear all");

    // R5 capture mode
    mode = 2'd2; cnt_val = 16'h0000;
    step("R5 setup");
    cnt_val = 16'h1205;
    step("R5 A blocked mode2");
    cnt_val = 16'h0012;
    step("R4 B blocked mode2");
    cap_evt = 1;
    step("R6 pin capture mode2");
    top_stb = 1; wr_en = 1; wr_data = 8'h01;
    step("R6 top ignored mode2");

    // R6 capture-as-TOP
    mode = 2'd3; cnt_val = 16'h0100;
    cap_evt = 1;
    step("R6 pin ignored mode3");
    top_stb = 1;
    step("R6 top sets mode3");

    // R11 gating
    gie = 0;
    step("R11 gie off");
    gie = 1; src_en = 4'b1110;
    step("R11 src off");
    src_en = 4'hF;
    step("R11 all on");

    // Constrained random
    for (int k = 0; k < 4000; k++) begin
      mode    = 2'($urandom_range(0, 3));
      cmp_a   = 8'($urandom_range(0, 3));
      cmp_b   = 8'($urandom_range(0, 3));
      cnt_val = {8'($urandom_range(0, 3)), 8'($urandom_range(0, 3))};
      if ($urandom_range(0, 2) == 0) begin
        cnt_val = cnt_val;
      end
      ovf_stb = ($urandom_range(0, 5) == 0);
      cap_evt = ($urandom_range(0, 4) == 0);
      top_stb = ($urandom_range(0, 4) == 0);
      wr_en   = ($urandom_range(0, 3) == 0);
      wr_data = 8'($urandom);
      ack     = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      gie     = ($urandom_range(0, 4) != 0);
      src_en  = 4'($urandom);
      step("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule